// File: doc/BRIEF.md
# Scoreboard Issue Controller

This block is the hazard-tracking controller of a small out-of-order execution core. Decoded three-operand instructions (an operation class, one destination and two source register numbers, each a 3-bit specifier into eight registers) arrive on a single input in program order. The controller assigns each one to a free functional unit of the matching class. It then lets each unit fetch its operands once they are valid and lets each finished unit write its result once no older instruction still needs the register's previous contents. Register specifiers are the only fields compared for dependences.

Each functional unit is modelled as a non-pipelined execution resource with a fixed busy time. The outputs are per-unit grant vectors for dispatch, operand read and write-back, plus the register being written. A register result table records which unit owns the pending write of each register. Each unit remembers its sources, their producing units and a valid flag per source, so instructions start out of order as their data becomes valid and may finish out of order.

Top module: `sbd_issue_ctl`

## Requirements
- R1: A request with `in_valid` high and `in_ready` high is dispatched in the same cycle to the lowest-numbered idle unit of class `in_type`; unit u has class u / UPT (defaults: units 0 and 1 class 0, units 2 and 3 class 1). `disp_grant` is one-hot for that unit. A stalled request holds the input, so later instructions never pass it.
- R2: `in_ready` is low while every unit of the requested class is busy, and goes high in the cycle after one of them is granted write-back.
- R3: `in_ready` is low while the requested destination has a pending write, including that write's write-back cycle, and is high again in the following cycle.
- R4: A unit is granted operand read only when both its sources are valid; with no pending producers the read grant comes one cycle after dispatch, never in the dispatch cycle.
- R5: A unit's earliest write-back grant comes LAT+1 cycles after its read grant. A later instruction may therefore write back before an earlier one that is still waiting.
- R6: A finished unit is not granted write-back while any other unit still waits to read a valid, unread source equal to its destination; it becomes eligible in the cycle after that unit's read grant.
- R7: A consumer of a register is granted operand read in the cycle after the producer's write-back grant, also when the consumer was dispatched in that very write-back cycle.
- R8: At most one unit is granted write-back per cycle; among eligible units the lowest-numbered wins, and `wb_reg` shows that unit's destination register.
- R9: After reset all units are idle, no grant is active and a request of any class with any destination is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented |
| in_type | input | TW | Functional-unit class required |
| in_dst | input | RW | Destination register |
| in_src1 | input | RW | First source register |
| in_src2 | input | RW | Second source register |
| in_ready | output | 1 | Presented instruction can be dispatched this cycle |
| disp_grant | output | NU | Unit receiving the instruction this cycle |
| read_grant | output | NU | Units reading their operands this cycle |
| wb_grant | output | NU | Unit writing its result this cycle |
| wb_reg | output | RW | Register written by the granted unit |

## Verification
The dispatch grant and `in_ready` respond combinationally in the request's own cycle. An independent read follows one cycle after dispatch, the earliest write-back follows LAT+1 cycles after the read, and a woken consumer reads one cycle after its producer's write-back. The bench numbers cycles from the first cycle after reset release and drives each input on the falling edge. It samples the combinational grants a moment later in the same cycle, so every expected value is tied to a precomputed cycle number: the one where the grant is due and, where a mutation would move it earlier, the cycle before it.

// File: rtl/sbd_issue_ctl.sv
module sbd_issue_ctl #(
  parameter int NREG  = 8,
  parameter int NTYPE = 2,
  parameter int UPT   = 2,
  parameter int LAT   = 3,
  localparam int NU = NTYPE * UPT,
  localparam int RW = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int TW = (NTYPE > 1) ? $clog2(NTYPE) : 1,
  localparam int UW = (NU > 1) ? $clog2(NU) : 1,
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [TW-1:0] in_type,
  input  logic [RW-1:0] in_dst,
  input  logic [RW-1:0] in_src1,
  input  logic [RW-1:0] in_src2,
  output logic          in_ready,
  output logic [NU-1:0] disp_grant,
  output logic [NU-1:0] read_grant,
  output logic [NU-1:0] wb_grant,
  output logic [RW-1:0] wb_reg
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_EXEC, S_DONE} ust_t;

  function automatic logic [UW-1:0] enc(input logic [NU-1:0] v);
    enc = '0;
    for (int i = NU - 1; i >= 0; i--)
      if (v[i]) enc = UW'(i);
  endfunction

  ust_t          st   [NU];
  logic [RW-1:0] dst  [NU];
  logic [RW-1:0] s1   [NU];
  logic [RW-1:0] s2   [NU];
  logic [UW-1:0] q1   [NU];
  logic [UW-1:0] q2   [NU];
  logic [CW-1:0] cnt  [NU];
  logic [NU-1:0] r1, r2;

  logic [NREG-1:0] own_v;
  logic [UW-1:0]   own_u [NREG];

  logic [NU-1:0] cand, wb_req, war_hold;
  logic [UW-1:0] disp_idx, wb_idx;
  logic          fire, wb_any, rdy1_in, rdy2_in;

  assign in_ready   = (|cand) && !own_v[in_dst];
  assign fire       = in_valid && in_ready;
  assign disp_grant = fire ? (cand & (~cand + 1'b1)) : '0;
  assign disp_idx   = enc(disp_grant);
  assign wb_grant   = wb_req & (~wb_req + 1'b1);
  assign wb_any     = |wb_req;
  assign wb_idx     = enc(wb_grant);
  assign wb_reg     = wb_any ? dst[wb_idx] : '0;
  assign rdy1_in    = !own_v[in_src1] || (wb_any && own_u[in_src1] == wb_idx);
  assign rdy2_in    = !own_v[in_src2] || (wb_any && own_u[in_src2] == wb_idx);

  for (genvar u = 0; u < NU; u++) begin : g_unit
    assign cand[u]       = (st[u] == S_IDLE) && (in_type == TW'(u / UPT));
    assign read_grant[u] = (st[u] == S_WAIT) && r1[u] && r2[u];
    assign wb_req[u]     = (st[u] == S_DONE) && !war_hold[u];

    always_comb begin
      war_hold[u] = 1'b0;
      for (int g = 0; g < NU; g++)
        if (st[g] == S_WAIT &&
            ((r1[g] && s1[g] == dst[u]) || (r2[g] && s2[g] == dst[u])))
          war_hold[u] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st[u]  <= S_IDLE;
        dst[u] <= '0;
        s1[u]  <= '0;
        s2[u]  <= '0;
        q1[u]  <= '0;
        q2[u]  <= '0;
        r1[u]  <= 1'b0;
        r2[u]  <= 1'b0;
        cnt[u] <= '0;
      end else begin
        case (st[u])
          S_IDLE: if (disp_grant[u]) begin
            st[u]  <= S_WAIT;
            dst[u] <= in_dst;
            s1[u]  <= in_src1;
            s2[u]  <= in_src2;
            q1[u]  <= own_u[in_src1];
            q2[u]  <= own_u[in_src2];
            r1[u]  <= rdy1_in;
            r2[u]  <= rdy2_in;
          end
          S_WAIT: if (read_grant[u]) begin
            st[u]  <= S_EXEC;
            cnt[u] <= CW'(LAT - 1);
          end else begin
            if (wb_any && !r1[u] && q1[u] == wb_idx) r1[u] <= 1'b1;
            if (wb_any && !r2[u] && q2[u] == wb_idx) r2[u] <= 1'b1;
          end
          S_EXEC: if (cnt[u] == '0) st[u] <= S_DONE;
                  else cnt[u] <= cnt[u] - 1'b1;
          S_DONE: if (wb_grant[u]) st[u] <= S_IDLE;
          default: st[u] <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_v <= '0;
      for (int r = 0; r < NREG; r++) own_u[r] <= '0;
    end else begin
      if (wb_any) own_v[wb_reg] <= 1'b0;
      if (fire) begin
        own_v[in_dst] <= 1'b1;
        own_u[in_dst] <= disp_idx;
      end
    end
  end
endmodule

// File: rtl/sbd_issue_ctl_chk.sv
module sbd_issue_ctl_chk #(
  parameter int NREG  = 8,
  parameter int NTYPE = 2,
  parameter int UPT   = 2,
  localparam int NU = NTYPE * UPT,
  localparam int RW = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int TW = (NTYPE > 1) ? $clog2(NTYPE) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [TW-1:0] in_type,
  input logic [RW-1:0] in_dst,
  input logic          in_ready,
  input logic [NU-1:0] disp_grant,
  input logic [NU-1:0] read_grant,
  input logic [NU-1:0] wb_grant,
  input logic [RW-1:0] wb_reg
);
  assert_disp_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(disp_grant));

  assert_unit_busy_after_disp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|disp_grant) |=> ((disp_grant & $past(disp_grant)) == '0));

  assert_no_reuse_of_written_dst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready && (|wb_grant) && wb_reg == in_dst));

  assert_no_read_at_dispatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (read_grant & disp_grant) == '0);

  assert_read_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|read_grant) |=> ((read_grant & $past(read_grant)) == '0));

  assert_read_not_with_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (read_grant & wb_grant) == '0);

  assert_wb_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wb_grant));

  assert_wb_unit_freed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|wb_grant) |=> ((wb_grant & $past(wb_grant)) == '0));
endmodule

bind sbd_issue_ctl sbd_issue_ctl_chk #(.NREG(NREG), .NTYPE(NTYPE), .UPT(UPT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_type(in_type), .in_dst(in_dst),
  .in_ready(in_ready), .disp_grant(disp_grant), .read_grant(read_grant),
  .wb_grant(wb_grant), .wb_reg(wb_reg)
);

// File: tb/sbd_issue_ctl_bench.sv
module sbd_issue_ctl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [0:0] in_type = '0;
  logic [2:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic       in_ready;
  logic [3:0] disp_grant, read_grant, wb_grant;
  logic [2:0] wb_reg;

  int checks = 0;
  int errors = 0;
  int cyc = -1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sbd_issue_ctl u_sbd_issue_ctl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_type(in_type),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2), .in_ready(in_ready),
    .disp_grant(disp_grant), .read_grant(read_grant), .wb_grant(wb_grant),
    .wb_reg(wb_reg)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s (cycle %0d): got %0h expected %0h", tag, cyc, got, exp);
    end
  endtask

  task automatic step(input logic v, input logic t, input logic [2:0] d,
                      input logic [2:0] a, input logic [2:0] b);
    @(negedge clk);
    in_valid = v; in_type = t; in_dst = d; in_src1 = a; in_src2 = b;
    cyc++;
    #1;
  endtask

  task automatic idle_to(input int k);
    while (cyc < k) step(1'b0, 1'b0, 3'd0, 3'd0, 3'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cyc = -1;
  endtask

  task automatic t_reset();
    do_reset();
    step(1'b0, 1'b1, 3'd7, 3'd0, 3'd0);
    chk("R9 disp idle", 8'(disp_grant), 8'h0);
    chk("R9 read idle", 8'(read_grant), 8'h0);
    chk("R9 wb idle", 8'(wb_grant), 8'h0);
    chk("R9 ready", 8'(in_ready), 8'h1);
  endtask

  task automatic t_indep();
    do_reset();
    step(1'b1, 1'b0, 3'd1, 3'd2, 3'd3);
    chk("R1 disp lowest class0", 8'(disp_grant), 8'h1);
    step(1'b0, 1'b0, 3'd0, 3'd0, 3'd0);
    chk("R4 read after dispatch", 8'(read_grant), 8'h1);
    idle_to(4);
    chk("R5 no early wb", 8'(wb_grant), 8'h0);
    step(1'b0, 1'b0, 3'd0, 3'd0, 3'd0);
    chk("R5 wb due", 8'(wb_grant), 8'h1);
    chk("R8 wb_reg", 8'(wb_reg), 8'h1);
  endtask

  task automatic t_struct();
    do_reset();
    step(1'b1, 1'b0, 3'd1, 3'd0, 3'd0);
    chk("R1 first unit", 8'(disp_grant), 8'h1);
    step(1'b1, 1'b0, 3'd2, 3'd0, 3'd0);
    chk("R1 next unit same class", 8'(disp_grant), 8'h2);
    step(1'b1, 1'b0, 3'd3, 3'd0, 3'd0);
    chk("R2 class full stall", 8'(in_ready), 8'h0);
    chk("R2 no grant when full", 8'(disp_grant), 8'h0);
    in_type = 1'b1; #1;
    chk("R1 other class lowest", 8'(disp_grant), 8'h4);
    step(1'b1, 1'b0, 3'd4, 3'd0, 3'd0);
    idle_keep(5);
    chk("R2 still full in wb cycle", 8'(in_ready), 8'h0);
    step(1'b1, 1'b0, 3'd4, 3'd0, 3'd0);
    chk("R2 freed unit granted", 8'(disp_grant), 8'h1);
  endtask

  task automatic idle_keep(input int k);
    while (cyc < k) step(in_valid, in_type, in_dst, in_src1, in_src2);
  endtask

  task automatic t_waw();
    do_reset();
    step(1'b1, 1'b0, 3'd1, 3'd2, 3'd3);
    step(1'b1, 1'b1, 3'd1, 3'd2, 3'd3);
    chk("R3 pending dst stall", 8'(in_ready), 8'h0);
    idle_keep(5);
    chk("R3 stall in wb cycle", 8'(in_ready), 8'h0);
    chk("R3 wb seen", 8'(wb_grant), 8'h1);
    step(1'b1, 1'b1, 3'd1, 3'd2, 3'd3);
    chk("R3 released", 8'(disp_grant), 8'h4);
  endtask

  task automatic t_raw();
    do_reset();
    step(1'b1, 1'b0, 3'd1, 3'd2, 3'd3);
    step(1'b1, 1'b1, 3'd4, 3'd1, 3'd5);
    chk("R4 consumer dispatched", 8'(disp_grant), 8'h4);
    idle_to(5);
    chk("R4 consumer waits", 8'(read_grant), 8'h0);
    chk("R7 producer wb", 8'(wb_grant), 8'h1);
    step(1'b0, 1'b0, 3'd0, 3'd0, 3'd0);
    chk("R7 wakeup read", 8'(read_grant), 8'h4);
    idle_to(10);
    chk("R5 consumer wb", 8'(wb_grant), 8'h4);
    chk("R8 consumer wb_reg", 8'(wb_reg), 8'h4);

    do_reset();
    step(1'b1, 1'b0, 3'd1, 3'd2, 3'd3);
    idle_to(4);
    step(1'b1, 1'b1, 3'd4, 3'd1, 3'd1);
    chk("R7 dispatch during wb", 8'(disp_grant), 8'h4);
    step(1'b0, 1'b0, 3'd0, 3'd0, 3'd0);
    chk("R7 same-cycle wakeup read", 8'(read_grant), 8'h4);
  endtask

  task automatic t_ooo();
    do_reset();
    step(1'b1, 1'b0, 3'd1, 3'd2, 3'd3);
    step(1'b1, 1'b1, 3'd2, 3'd1, 3'd4);
    step(1'b1, 1'b1, 3'd5, 3'd6, 3'd7);
    chk("R1 second class1 unit", 8'(disp_grant), 8'h8);
    idle_to(7);
    chk("R5 later instr first", 8'(wb_grant), 8'h8);
    chk("R5 later wb_reg", 8'(wb_reg), 8'h5);
    idle_to(10);
    chk("R5 earlier instr last", 8'(wb_grant), 8'h4);
    chk("R5 earlier wb_reg", 8'(wb_reg), 8'h2);
  endtask

  task automatic t_prio();
    do_reset();
    step(1'b1, 1'b1, 3'd6, 3'd2, 3'd3);
    step(1'b1, 1'b0, 3'd1, 3'd6, 3'd2);
    step(1'b1, 1'b0, 3'd3, 3'd6, 3'd4);
    chk("R1 unit1 taken", 8'(disp_grant), 8'h2);
    idle_to(6);
    chk("R7 both wake", 8'(read_grant), 8'h3);
    idle_to(10);
    chk("R8 lowest wins", 8'(wb_grant), 8'h1);
    chk("R8 winner reg", 8'(wb_reg), 8'h1);
    step(1'b0, 1'b0, 3'd0, 3'd0, 3'd0);
    chk("R8 loser next", 8'(wb_grant), 8'h2);
    chk("R8 loser reg", 8'(wb_reg), 8'h3);
  endtask

  task automatic t_war();
    do_reset();
    step(1'b1, 1'b0, 3'd6, 3'd2, 3'd3);
    step(1'b1, 1'b0, 3'd7, 3'd6, 3'd6);
    step(1'b1, 1'b1, 3'd4, 3'd1, 3'd7);
    step(1'b1, 1'b1, 3'd1, 3'd2, 3'd3);
    chk("R6 writer dispatched", 8'(disp_grant), 8'h8);
    idle_to(8);
    chk("R6 writer held", 8'(wb_grant), 8'h0);
    idle_to(11);
    chk("R6 reader reads", 8'(read_grant), 8'h4);
    chk("R6 held in read cycle", 8'(wb_grant), 8'h0);
    step(1'b0, 1'b0, 3'd0, 3'd0, 3'd0);
    chk("R6 writer released", 8'(wb_grant), 8'h8);
    chk("R6 writer reg", 8'(wb_reg), 8'h1);
  endtask

  initial begin
    t_reset();
    t_indep();
    t_struct();
    t_waw();
    t_raw();
    t_ooo();
    t_prio();
    t_war();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule